// File: doc/BRIEF.md
# Converter Result Output Port

This block is the device-side digital shell of a 14-bit successive-approximation converter. A counter models the conversion time, and a 14-bit sample input stands in for the analog result. A rising edge on the convert-start input begins a conversion. BUSY is high for a fixed number of clocks. When the conversion ends, the result is latched into an output register in the coding chosen when the conversion started. The older result stays visible on the bus until then.

The data bus is modelled as a value plus an output enable. It is driven only when chip select and read are both low, the serial/parallel select is low, and the device-reset input is low. Otherwise the enable is low and the value is forced to zero. The device-reset input acts on each of its two edges. Its rising edge aborts a conversion in progress and releases the bus. Its falling edge clears the stored result and the coding configuration. A separate asynchronous active-low system reset initialises every register.

Top module: `adc_output_port`

## Requirements
- R1: An accepted convert-start rising edge raises busy_o on the next clock, and busy_o stays high for exactly CONV_CLKS clocks (default 8).
- R2: A convert-start rising edge that arrives while busy_o is high is ignored: the busy period keeps its length and its result.
- R3: The output register holds the previous result for the whole conversion. It takes sample_i at the clock on which busy_o falls.
- R4: code_twos_i sampled with an accepted start selects the coding of that conversion. 0 gives straight binary (sample_i unchanged). 1 gives twos complement (sample_i with bit 13 inverted).
- R5: data_oe_o is 1 only while cs_n_i = 0, rd_n_i = 0, ser_sel_i = 0 and dev_reset_i = 0. Whenever data_oe_o is 0, data_o reads 0.
- R6: ser_sel_i = 1 disables the parallel bus even with cs_n_i = rd_n_i = 0.
- R7: A rising edge of dev_reset_i aborts a conversion: busy_o is low on the next clock, the bus is released, and the aborted sample is never latched.
- R8: A falling edge of dev_reset_i clears the stored result and the coding to straight binary, so the bus then reads 0.
- R9: While dev_reset_i is high, busy_o stays low and convert-start edges are ignored.
- R10: With cs_n_i and rd_n_i held low, the bus continuously shows the most recent result and changes with no read strobe.
- R11: While rst_n is low, busy_o is 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| conv_start_i | input | 1 | Convert start, acts on its rising edge |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read enable, active low |
| dev_reset_i | input | 1 | Device reset: rise aborts, fall clears |
| ser_sel_i | input | 1 | 1 selects serial mode and disables the parallel bus |
| code_twos_i | input | 1 | 1 selects twos complement output coding |
| sample_i | input | 14 | Stand-in for the analog conversion result |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 14 | Bus value, 0 when not driven |
| data_oe_o | output | 1 | Bus output enable |

## Verification
Inputs change on the falling clock edge, and outputs are sampled on the next falling edge, half a period after the rising edge that updates them. Start edges and the device-reset edges pass through one register, so busy_o and the cleared result are checked one clock after the stimulus. The new result is checked CONV_CLKS + 1 clocks after the start, at the same falling edge where busy_o is first seen low. The bus enable and value are combinational in the select inputs and are checked a few nanoseconds after those inputs change. Abort is checked by waiting more than a full conversion time after the device reset is released and confirming that no late capture appears.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  localparam int unsigned DEF_SAMPLE_BITS = 14;
  localparam int unsigned DEF_CONV_CLKS   = 8;

  typedef enum logic {
    CODE_STRAIGHT = 1'b0,
    CODE_TWOS     = 1'b1
  } code_e;

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hold_i,
  output logic busy_o,
  output logic accept_o,
  output logic done_o
);

  localparam int unsigned CW = (CONV_CLKS > 1) ? $clog2(CONV_CLKS) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CONV_CLKS - 1);

  logic          start_q, start_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          start_edge;

  always_comb begin
    start_edge = start_i & ~start_q;
    accept_o   = start_edge & ~busy_q & ~hold_i;
    done_o     = busy_q & (cnt_q == '0) & ~hold_i;
    start_d    = start_i;
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    if (hold_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - CW'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_d;
      busy_q  <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o && (cnt_q == LOAD)); // R1
  AST_BUSY_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !hold_i && (cnt_q != '0)) |=> busy_q && (cnt_q == $past(cnt_q) - CW'(1))); // R2
  AST_NO_BUSY_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !busy_o); // R9
  AST_ABORT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_i) |=> !busy_o && !done_o); // R7

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adc_port_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic         code_twos_i,
  input  logic         done_i,
  input  logic         hold_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] result_o
);

  logic [W-1:0] raw_q, raw_d;
  code_e        pend_q, pend_d;
  code_e        cfg_q, cfg_d;
  logic         hold_prev_q;
  logic         clear;
  logic         raw_en;

  always_comb begin
    clear  = ~hold_i & hold_prev_q;
    raw_d  = raw_q;
    cfg_d  = cfg_q;
    pend_d = pend_q;
    raw_en = 1'b0;
    if (accept_i) pend_d = code_e'(code_twos_i);
    if (clear) begin
      raw_d  = '0;
      cfg_d  = CODE_STRAIGHT;
      pend_d = CODE_STRAIGHT;
      raw_en = 1'b1;
    end else if (done_i) begin
      raw_d  = sample_i;
      cfg_d  = pend_q;
      raw_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q       <= '0;
      cfg_q       <= CODE_STRAIGHT;
      pend_q      <= CODE_STRAIGHT;
      hold_prev_q <= 1'b0;
    end else begin
      hold_prev_q <= hold_i;
      pend_q      <= pend_d;
      if (raw_en) begin
        raw_q <= raw_d;
        cfg_q <= cfg_d;
      end
    end
  end

  assign result_o = raw_q ^ {(cfg_q == CODE_TWOS), {(W-1){1'b0}}};

  AST_HOLD_PREVIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !clear) |=> $stable(raw_q) && $stable(cfg_q)); // R3
  AST_CAPTURE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !clear) |=> raw_q == $past(sample_i)); // R3
  AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_i) |=> (result_o == '0)); // R8

endmodule

// File: rtl/adc_bus_gate.sv
module adc_bus_gate #(
  parameter int unsigned W = 14
) (
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  input  logic         ser_sel_i,
  input  logic         hold_i,
  input  logic [W-1:0] result_i,
  output logic [W-1:0] data_o,
  output logic         oe_o
);

  always_comb begin
    oe_o   = ~cs_n_i & ~rd_n_i & ~ser_sel_i & ~hold_i;
    data_o = oe_o ? result_i : '0;
  end

endmodule

// File: rtl/adc_output_port.sv
module adc_output_port
  import adc_port_pkg::*;
#(
  parameter int unsigned SAMPLE_BITS = DEF_SAMPLE_BITS,
  parameter int unsigned CONV_CLKS   = DEF_CONV_CLKS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   conv_start_i,
  input  logic                   cs_n_i,
  input  logic                   rd_n_i,
  input  logic                   dev_reset_i,
  input  logic                   ser_sel_i,
  input  logic                   code_twos_i,
  input  logic [SAMPLE_BITS-1:0] sample_i,
  output logic                   busy_o,
  output logic [SAMPLE_BITS-1:0] data_o,
  output logic                   data_oe_o
);

  logic                   accept;
  logic                   done;
  logic [SAMPLE_BITS-1:0] result;

  adc_conv_timer #(.CONV_CLKS(CONV_CLKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (conv_start_i),
    .hold_i   (dev_reset_i),
    .busy_o   (busy_o),
    .accept_o (accept),
    .done_o   (done)
  );

  adc_result_store #(.W(SAMPLE_BITS)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .code_twos_i (code_twos_i),
    .done_i      (done),
    .hold_i      (dev_reset_i),
    .sample_i    (sample_i),
    .result_o    (result)
  );

  adc_bus_gate #(.W(SAMPLE_BITS)) u_gate (
    .cs_n_i    (cs_n_i),
    .rd_n_i    (rd_n_i),
    .ser_sel_i (ser_sel_i),
    .hold_i    (dev_reset_i),
    .result_i  (result),
    .data_o    (data_o),
    .oe_o      (data_oe_o)
  );

  AST_BUS_RELEASED_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_i |-> !data_oe_o && (data_o == '0)); // R7

endmodule

// File: tb/test_adc_output_port.sv
module test_adc_output_port;

  localparam int unsigned N = 8;
  localparam int unsigned W = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv_start = 1'b0;
  logic         cs_n = 1'b1;
  logic         rd_n = 1'b1;
  logic         dev_reset = 1'b0;
  logic         ser_sel = 1'b0;
  logic         code_twos = 1'b0;
  logic [W-1:0] sample = '0;
  logic         busy;
  logic [W-1:0] data;
  logic         data_oe;

  int vectors = 0;
  int errors  = 0;
  bit summary_done = 1'b0;

  always #10 clk = ~clk;

  adc_output_port #(.SAMPLE_BITS(W), .CONV_CLKS(N)) i_adc_output_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start_i (conv_start),
    .cs_n_i       (cs_n),
    .rd_n_i       (rd_n),
    .dev_reset_i  (dev_reset),
    .ser_sel_i    (ser_sel),
    .code_twos_i  (code_twos),
    .sample_i     (sample),
    .busy_o       (busy),
    .data_o       (data),
    .data_oe_o    (data_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
  endtask

  // Start a conversion, check busy and held data each cycle, then the new result.
  task automatic run_conv(input logic [W-1:0] s, input logic twos, input logic [W-1:0] prev);
    @(negedge clk);
    sample = s; code_twos = twos; conv_start = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      conv_start = 1'b0;
      check("R1 busy high", busy, 1);
      check("R3 previous held", data, prev);
    end
    @(negedge clk);
    check("R1 busy low after N", busy, 0);
    check("R4 coded result", data, twos ? (s ^ 14'h2000) : s);
  endtask

  task automatic t_reset_state();
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R11 busy in reset", busy, 0);
    check("R11 data in reset", data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 busy after reset", busy, 0);
    check("R11 data after reset", data, 0);
    check("R5 oe driven", data_oe, 1);
  endtask

  task automatic t_straight();
    run_conv(14'h1234, 1'b0, 14'h0000);
    run_conv(14'h0005, 1'b0, 14'h1234);
    check("R10 continuous oe", data_oe, 1);
    check("R10 latest shown", data, 14'h0005);
  endtask

  task automatic t_twos();
    run_conv(14'h0123, 1'b1, 14'h0005);
    run_conv(14'h3FFF, 1'b1, 14'h2123);
    run_conv(14'h0AAA, 1'b0, 14'h1FFF);
  endtask

  task automatic t_ignore_restart();
    @(negedge clk);
    sample = 14'h0333; code_twos = 1'b0; conv_start = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i == 0) conv_start = 1'b0;
      if (i == 2) begin conv_start = 1'b1; code_twos = 1'b1; end
      if (i == 4) conv_start = 1'b0;
      check("R2 busy kept", busy, 1);
    end
    @(negedge clk);
    check("R2 busy ends on time", busy, 0);
    check("R2 first coding kept", data, 14'h0333);
    @(negedge clk);
    check("R2 no second conversion", busy, 0);
    code_twos = 1'b0;
  endtask

  task automatic t_bus_gating();
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; #3;
    check("R5 cs high oe", data_oe, 0);
    check("R5 cs high data", data, 0);
    cs_n = 1'b0; rd_n = 1'b1; #3;
    check("R5 rd high oe", data_oe, 0);
    cs_n = 1'b1; rd_n = 1'b1; #3;
    check("R5 both high oe", data_oe, 0);
    cs_n = 1'b0; rd_n = 1'b0; ser_sel = 1'b1; #3;
    check("R6 serial oe", data_oe, 0);
    check("R6 serial data", data, 0);
    ser_sel = 1'b0; #3;
    check("R5 enabled oe", data_oe, 1);
    check("R5 enabled data", data, 14'h0333);
  endtask

  task automatic t_abort_clear();
    run_conv(14'h0010, 1'b1, 14'h0333);
    @(negedge clk);
    sample = 14'h0777; code_twos = 1'b0; conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    dev_reset = 1'b1;
    #3;
    check("R7 bus released", data_oe, 0);
    @(negedge clk);
    check("R7 busy aborted", busy, 0);
    conv_start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 1) conv_start = 1'b0;
      if (i == 2) conv_start = 1'b1;
      check("R9 no start in reset", busy, 0);
    end
    conv_start = 1'b0;
    dev_reset = 1'b0;
    @(negedge clk);
    check("R8 oe after release", data_oe, 1);
    check("R8 cleared result", data, 0);
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk);
      check("R7 no late capture", data, 0);
      check("R9 stays idle", busy, 0);
    end
    run_conv(14'h0042, 1'b0, 14'h0000);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    t_reset_state();
    t_straight();
    t_twos();
    t_ignore_restart();
    t_bus_gating();
    t_abort_clear();
    summary();
    $finish;
  end

endmodule